// File: doc/BRIEF.md
# Comparator Bus Conditioner and Combiner

This block takes the one-bit comparator buses of up to four analog columns and turns them into clean digital bits for the rest of the chip. Each bus first passes through a level latch that follows the bus while a two-phase clock phase signal is high and holds it while that phase is low. A per-column option keeps the latch permanently open. The held bit can then be gated by the primary output of one selected digital block, which is how an incremental ADC gets an exact integration window. Finally each column passes through a two-input, sixteen-function logic stage that can merge it with the next column around the ring.

The resulting bits drive digital-block data inputs, interrupt requests and a decimator. Software can read them in a status register. Configuration comes from a small synchronous register write port. A read port returns the configuration registers and the status word. Builds with one or two columns tie every missing comparator to 0 at the combiner.

Top module: `cmpbus_conditioner`

## Requirements
- R1: While `phi2` is high, or while a column's force-open bit is set, that column's latched bit equals its `cmpBus` bit in the same cycle, with no register delay.
- R2: While `phi2` is low and force-open is clear, a column's latched bit holds the `cmpBus` value sampled on the last rising `clk` edge at which `phi2` was high.
- R3: Register address 1 bits [3:0] are the force-open bits, bit n for column n.
- R4: Register address 1 bits [7:4] are gate enables, bit 4+n for column n. Register address 2 bits [2:0] select which `digBlk` bit is the gate. With the gate enabled and the selected bit low, the column's value is 0. With the gate enabled and the selected bit high, or with the gate disabled, the latched bit passes unchanged.
- R5: The combiner of column n takes A = gated column n and B = gated column (n+1) mod 4, so column 3 pairs with column 0.
- R6: The output is selected by a 4-bit function code: 0 FALSE, 1 A AND B, 2 A AND NOT B, 3 A, 4 NOT A AND B, 5 B, 6 A XOR B, 7 A OR B, 8 A NOR B, 9 A XNOR B, A NOT B, B A OR NOT B, C NOT A, D NOT A OR B, E A NAND B, F TRUE.
- R7: Register address 0 holds the four function codes, with column n's code in bits [4n+3:4n]. Writes at addresses 0 to 2 take effect from the next cycle and read back unchanged in their defined bits. Undefined bits read 0.
- R8: With NUM_COLS of 1 or 2, comparators at column indices NUM_COLS and above enter the combiner as 0.
- R9: Reading address 3 returns `cmpOut` in bits [3:0] and 0 above. Address 3 ignores writes.
- R10: After reset every held bit is 0, gating and force-open are off, and every function code is 3. A read of address 0 therefore returns 16'h3333.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| phi2 | input | 1 | Clock phase level; latches are open while high |
| cmpBus | input | 4 | Raw comparator bus, one bit per column |
| digBlk | input | 8 | Primary outputs of the digital blocks, candidates for the gate |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 16 | Register read data |
| cmpOut | output | 4 | Processed comparator bits per column |

## Verification
A long random run changes the phase level, the buses, the digital-block outputs and the configuration together. It is compared with a model, once for a four-column build and once for a one-column build, which separates correct pairing from a mistake in tying missing columns to 0. Directed steps cover the following cases:
- A phase fall while the bus changes in the same cycle, which shows whether the latch holds the old value or leaks the new one.
- A forced column beside held ones.
- A gate driven by a selected versus an unselected digital-block bit.
- All sixteen function codes over all four input pairs, so that any code with a bit reversed or placed wrongly shows up.

// File: rtl/cmpbus_pkg.sv
package cmpbus_pkg;
  localparam int MAX_COLS   = 4;
  localparam int CODE_W     = 4;
  localparam int DIG_SEL_W  = 3;
  localparam int REG_W      = MAX_COLS * CODE_W;
  localparam int ADDR_W     = 2;

  localparam logic [ADDR_W-1:0] ADDR_FUNC = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_SEL  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd3;

  localparam logic [CODE_W-1:0] CODE_PASS_A = 4'h3;

  typedef struct packed {
    logic [REG_W-1:0]     funcCodes;
    logic [MAX_COLS-1:0]  forceOpen;
    logic [MAX_COLS-1:0]  gateEn;
    logic [DIG_SEL_W-1:0] gateSel;
  } cfg_t;
endpackage

// File: rtl/cmpbus_cfg_regs.sv
module cmpbus_cfg_regs
  import cmpbus_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [REG_W-1:0]    wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [MAX_COLS-1:0] statusBits,
  output logic [REG_W-1:0]    rdData,
  output cfg_t                cfg
);
  localparam int CTRL_W = 2 * MAX_COLS;

  cfg_t cfgQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ.funcCodes <= {MAX_COLS{CODE_PASS_A}};
      cfgQ.forceOpen <= '0;
      cfgQ.gateEn    <= '0;
      cfgQ.gateSel   <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_FUNC: cfgQ.funcCodes <= wrData;
        ADDR_CTRL: begin
          cfgQ.forceOpen <= wrData[MAX_COLS-1:0];
          cfgQ.gateEn    <= wrData[CTRL_W-1:MAX_COLS];
        end
        ADDR_SEL:  cfgQ.gateSel <= wrData[DIG_SEL_W-1:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_FUNC: rdData = cfgQ.funcCodes;
      ADDR_CTRL: rdData[CTRL_W-1:0] = {cfgQ.gateEn, cfgQ.forceOpen};
      ADDR_SEL:  rdData[DIG_SEL_W-1:0] = cfgQ.gateSel;
      default:   rdData[MAX_COLS-1:0] = statusBits;
    endcase
  end

  assign cfg = cfgQ;
endmodule

// File: rtl/cmpbus_col_latch.sv
module cmpbus_col_latch (
  input  logic clk,
  input  logic rstN,
  input  logic phi2,
  input  logic forceOpen,
  input  logic busBit,
  output logic latched
);
  logic holdQ;

  always_ff @(posedge clk) begin
    if (!rstN)     holdQ <= 1'b0;
    else if (phi2) holdQ <= busBit;
  end

  assign latched = (phi2 || forceOpen) ? busBit : holdQ;
endmodule

// File: rtl/cmpbus_lut2.sv
module cmpbus_lut2
  import cmpbus_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              inA,
  input  logic              inB,
  output logic              result
);
  // code bit 0 is the output for A=1,B=1; bit 3 is the output for A=0,B=0
  logic [1:0] pick;
  assign pick   = {~inA, ~inB};
  assign result = code[pick];
endmodule

// File: rtl/cmpbus_datapath.sv
module cmpbus_datapath
  import cmpbus_pkg::*;
#(
  parameter int NUM_COLS = 4,
  parameter int NUM_DIG  = 1 << DIG_SEL_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                phi2,
  input  logic [MAX_COLS-1:0] cmpBus,
  input  logic [NUM_DIG-1:0]  digBlk,
  input  cfg_t                cfg,
  output logic [MAX_COLS-1:0] latchedBits,
  output logic [MAX_COLS-1:0] gatedBits,
  output logic [MAX_COLS-1:0] cmpOut
);
  logic gateLevel;
  assign gateLevel = digBlk[cfg.gateSel];

  for (genvar n = 0; n < MAX_COLS; n++) begin : g_col
    if (n < NUM_COLS) begin : g_present
      cmpbus_col_latch u_latch (
        .clk       (clk),
        .rstN      (rstN),
        .phi2      (phi2),
        .forceOpen (cfg.forceOpen[n]),
        .busBit    (cmpBus[n]),
        .latched   (latchedBits[n])
      );
      assign gatedBits[n] = latchedBits[n] & (gateLevel | ~cfg.gateEn[n]);
    end else begin : g_absent
      assign latchedBits[n] = 1'b0;
      assign gatedBits[n]   = 1'b0;
    end

    cmpbus_lut2 u_lut (
      .code   (cfg.funcCodes[n*CODE_W +: CODE_W]),
      .inA    (gatedBits[n]),
      .inB    (gatedBits[(n+1) % MAX_COLS]),
      .result (cmpOut[n])
    );
  end
endmodule

// File: rtl/cmpbus_conditioner.sv
module cmpbus_conditioner
  import cmpbus_pkg::*;
#(
  parameter int NUM_COLS = 4,
  parameter int NUM_DIG  = 1 << DIG_SEL_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                phi2,
  input  logic [MAX_COLS-1:0] cmpBus,
  input  logic [NUM_DIG-1:0]  digBlk,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [REG_W-1:0]    wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [REG_W-1:0]    rdData,
  output logic [MAX_COLS-1:0] cmpOut
);
  cfg_t                cfg;
  logic [MAX_COLS-1:0] latchedBits;
  logic [MAX_COLS-1:0] gatedBits;

  cmpbus_cfg_regs u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .rdAddr     (rdAddr),
    .statusBits (cmpOut),
    .rdData     (rdData),
    .cfg        (cfg)
  );

  cmpbus_datapath #(.NUM_COLS(NUM_COLS), .NUM_DIG(NUM_DIG)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .phi2        (phi2),
    .cmpBus      (cmpBus),
    .digBlk      (digBlk),
    .cfg         (cfg),
    .latchedBits (latchedBits),
    .gatedBits   (gatedBits),
    .cmpOut      (cmpOut)
  );
endmodule

// File: rtl/cmpbus_checker.sv
module cmpbus_checker
  import cmpbus_pkg::*;
#(
  parameter int NUM_COLS = 4,
  parameter int NUM_DIG  = 1 << DIG_SEL_W
) (
  input logic                clk,
  input logic                rstN,
  input logic                phi2,
  input logic [MAX_COLS-1:0] cmpBus,
  input logic [NUM_DIG-1:0]  digBlk,
  input logic [ADDR_W-1:0]   rdAddr,
  input logic [REG_W-1:0]    rdData,
  input logic [MAX_COLS-1:0] cmpOut,
  input cfg_t                cfg,
  input logic [MAX_COLS-1:0] latchedBits,
  input logic [MAX_COLS-1:0] gatedBits
);
  for (genvar n = 0; n < MAX_COLS; n++) begin : g_chk
    if (n < NUM_COLS) begin : g_live
      AST_OPEN_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
        (phi2 || cfg.forceOpen[n]) |-> latchedBits[n] == cmpBus[n]); // R1
      AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
        (!phi2 && !cfg.forceOpen[n] && !$past(phi2) && !$past(cfg.forceOpen[n]))
          |-> latchedBits[n] == $past(latchedBits[n])); // R2
    end else begin : g_dead
      AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
        gatedBits[n] == 1'b0); // R8
    end
    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
      (cfg.gateEn[n] && !digBlk[cfg.gateSel]) |-> !gatedBits[n]); // R4
    AST_GATE_OFF_PASS: assert property (@(posedge clk) disable iff (!rstN)
      !cfg.gateEn[n] |-> gatedBits[n] == latchedBits[n]); // R4
  end

  AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_STAT) |-> rdData == {{(REG_W-MAX_COLS){1'b0}}, cmpOut}); // R9
endmodule

bind cmpbus_conditioner cmpbus_checker #(.NUM_COLS(NUM_COLS), .NUM_DIG(NUM_DIG)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .phi2        (phi2),
  .cmpBus      (cmpBus),
  .digBlk      (digBlk),
  .rdAddr      (rdAddr),
  .rdData      (rdData),
  .cmpOut      (cmpOut),
  .cfg         (cfg),
  .latchedBits (latchedBits),
  .gatedBits   (gatedBits)
);

// File: tb/cmpbus_conditioner_tb.sv
module cmpbus_conditioner_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        phi2 = 1'b0;
  logic [3:0]  cmpBus = '0;
  logic [7:0]  digBlk = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] rdData, rdData1;
  logic [3:0]  cmpOut, cmpOut1;

  int vecCount = 0;
  int errCount = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cmpbus_conditioner u_dut (
    .clk(clk), .rstN(rstN), .phi2(phi2), .cmpBus(cmpBus), .digBlk(digBlk),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .cmpOut(cmpOut));

  cmpbus_conditioner #(.NUM_COLS(1)) u_dut1 (
    .clk(clk), .rstN(rstN), .phi2(phi2), .cmpBus(cmpBus), .digBlk(digBlk),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData1), .cmpOut(cmpOut1));

  // reference state
  logic [15:0] mCode;
  logic [3:0]  mForce, mGate, mHold;
  logic [2:0]  mSel;

  always @(posedge clk) begin
    if (!rstN) begin
      mCode <= 16'h3333; mForce <= '0; mGate <= '0; mSel <= '0; mHold <= '0;
    end else begin
      if (wrEn) begin
        case (wrAddr)
          2'd0: mCode <= wrData;
          2'd1: begin mForce <= wrData[3:0]; mGate <= wrData[7:4]; end
          2'd2: mSel <= wrData[2:0];
          default: ;
        endcase
      end
      if (phi2) mHold <= cmpBus;
    end
  end

  function automatic logic lutRef(input logic [3:0] code, input logic a, input logic b);
    case (code)
      4'h0: return 1'b0;
      4'h1: return a & b;
      4'h2: return a & ~b;
      4'h3: return a;
      4'h4: return ~a & b;
      4'h5: return b;
      4'h6: return a ^ b;
      4'h7: return a | b;
      4'h8: return ~(a | b);
      4'h9: return ~(a ^ b);
      4'hA: return ~b;
      4'hB: return a | ~b;
      4'hC: return ~a;
      4'hD: return ~a | b;
      4'hE: return ~(a & b);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [3:0] expOut(input int ncols);
    logic [3:0] g, o;
    for (int n = 0; n < 4; n++) begin
      logic lat;
      lat = (phi2 || mForce[n]) ? cmpBus[n] : mHold[n];
      if (n >= ncols) lat = 1'b0;
      g[n] = mGate[n] ? (lat & digBlk[mSel]) : lat;
    end
    for (int n = 0; n < 4; n++)
      o[n] = lutRef(mCode[4*n +: 4], g[n], g[(n+1)%4]);
    return o;
  endfunction

  function automatic logic [15:0] expRd(input int ncols);
    case (rdAddr)
      2'd0: return mCode;
      2'd1: return {8'h00, mGate, mForce};
      2'd2: return {13'h0, mSel};
      default: return {12'h0, expOut(ncols)};
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
    #1;
  endtask

  task automatic drive(input logic p, input logic [3:0] bus, input logic [7:0] dig);
    @(negedge clk); phi2 = p; cmpBus = bus; digBlk = dig;
    #1;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!finished) begin
      errCount++; vecCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7731));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10 reset state
    rdAddr = 2'd0; #1;
    check("R10 codes after reset", rdData, 16'h3333);
    check("R10 output after reset", {12'h0, cmpOut}, 16'h0000);
    // R1 transparent
    drive(1'b1, 4'b1010, 8'h00);
    check("R1 open follows bus", {12'h0, cmpOut}, 16'h000A);
    // R2 hold while low, bus changes at the fall
    drive(1'b0, 4'b0101, 8'h00);
    check("R2 hold old value", {12'h0, cmpOut}, 16'h000A);
    // R3 force-open column 0
    writeReg(2'd1, 16'h0001);
    check("R3 force column 0", {12'h0, cmpOut}, 16'h000B);
    // R4 gate column 1 by digital block 5
    writeReg(2'd2, 16'h0005);
    writeReg(2'd1, 16'h0020);
    drive(1'b0, 4'b0101, 8'h00);
    check("R4 gate low clears", {12'h0, cmpOut}, 16'h0008);
    drive(1'b0, 4'b0101, 8'h20);
    check("R4 gate high passes", {12'h0, cmpOut}, 16'h000A);
    drive(1'b0, 4'b0101, 8'h10);
    check("R4 unselected block ignored", {12'h0, cmpOut}, 16'h0008);
    // R7 readback
    rdAddr = 2'd1; #1;
    check("R7 ctrl readback", rdData, 16'h0020);
    rdAddr = 2'd2; #1;
    check("R7 select readback", rdData, 16'h0005);
    // R6 every code on column 0, all inputs forced open
    writeReg(2'd1, 16'h000F);
    for (int c = 0; c < 16; c++) begin
      writeReg(2'd0, {12'h333, c[3:0]});
      for (int ab = 0; ab < 4; ab++) begin
        logic a, b;
        a = ab[1]; b = ab[0];
        drive(1'b0, {2'b00, b, a}, 8'h00);
        check($sformatf("R6 code %0h a=%0d b=%0d", c, a, b),
              {15'h0, cmpOut[0]}, {15'h0, lutRef(c[3:0], a, b)});
      end
    end
    // R5 column 3 pairs with column 0 (XOR)
    writeReg(2'd0, 16'h6333);
    drive(1'b0, 4'b1000, 8'h00);
    check("R5 col3 xor col0 1,0", {15'h0, cmpOut[3]}, 16'h0001);
    drive(1'b0, 4'b1001, 8'h00);
    check("R5 col3 xor col0 1,1", {15'h0, cmpOut[3]}, 16'h0000);
    // R8 one-column build
    writeReg(2'd0, 16'h3333);
    drive(1'b0, 4'b1111, 8'h00);
    check("R8 one column ties others", {12'h0, cmpOut1}, 16'h0001);
    writeReg(2'd0, 16'h5333);
    check("R8 col3 sees comparator 0 as B", {12'h0, cmpOut1}, 16'h0009);
    // R9 status read and write ignored at address 3
    writeReg(2'd3, 16'hFFFF);
    rdAddr = 2'd3; #1;
    check("R9 status mirrors output", rdData, {12'h0, cmpOut});
    rdAddr = 2'd0; #1;
    check("R9 status write ignored", rdData, 16'h5333);
    // random mix: R1 R2 R4 R5 R6 R8 R9
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      phi2   = $urandom_range(0, 1);
      cmpBus = 4'($urandom);
      digBlk = 8'($urandom);
      rdAddr = 2'($urandom);
      wrEn   = ($urandom_range(0, 7) == 0);
      wrAddr = 2'($urandom);
      wrData = 16'($urandom);
      #1;
      check("R1 R2 R4 R5 R6 random four-column", {12'h0, cmpOut}, {12'h0, expOut(4)});
      check("R7 R9 random read", rdData, expRd(4));
      check("R8 random one-column", {12'h0, cmpOut1}, {12'h0, expOut(1)});
    end
    wrEn = 1'b0;
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule